// File: doc/BRIEF.md
# TDM Time-Slot Router

The router sits between one serial time-division multiplexed line and five internal serial controllers. It counts bits and 8-bit slots from a detected frame sync. Each slot is owned by one controller or by nobody, and ownership is found by walking a table of run-length entries. Each entry covers a number of consecutive slots and names a destination. Receive and transmit keep separate tables and separate timing engines.

The line-side clock and sync inputs are sampled with the block clock, which must run several times faster than the line clock. A configuration set selects:
- which line clock edge launches transmit data (receive sampling uses the other edge);
- which edge samples frame sync, and the sync polarity;
- a 0 to 3 bit delay from sync to the first bit, set separately for each direction;
- a double-speed line clock;
- a shared-pins mode, where the receive clock and sync pins time both directions.

On receive, each routed bit produces a one-cycle strobe to its controller, together with the bit value and the slot index. On transmit, the bit comes from the owning controller's data input, that controller receives a one-cycle strobe, and unrouted slots send ones.

Top module: `tdm_slot_router`

## Requirements
- R1: Table entry e holds a run-length code L (slot count L+1, 1..64) and a destination. Entries are used in address order from entry 0: slot s belongs to the first entry whose running slot total exceeds s. For a slot owned by destination d in 1..5, every received bit raises bit d-1 of `rx_stb` for one clock, with that bit on `rx_bit` and the slot index on `rx_slot`.
- R2: Destination codes 0, 6 and 7 mean unrouted. An unrouted receive slot strobes no controller, and an unrouted transmit slot drives `tx_data` high.
- R3: Slots past the last of the `cfg_rx_cnt`/`cfg_tx_cnt` entries are unrouted, and all slots are unrouted when the count is 0.
- R4: With delay D (`cfg_rx_dly`, `cfg_tx_dly`), the first bit of a frame falls on the (D+1)-th bit event after the edge on which sync was detected. A data edge that coincides with the sync edge is not counted.
- R5: With `cfg_tx_on_fall`=1, transmit bits launch on the falling line-clock edge and receive bits are sampled on the rising edge. With `cfg_tx_on_fall`=0, the two edges swap.
- R6: Sync is sampled on the rising edge when `cfg_sync_rise`=1 and on the falling edge otherwise. It is active low when `cfg_sync_low`=1 and active high otherwise.
- R7: With `cfg_dbl`=1, a bit event occurs only on every second data edge after sync, the first being the second edge.
- R8: With `cfg_common`=1, transmit timing uses `rx_clk` and `rx_sync`, and `tx_clk` and `tx_sync` are ignored. With `cfg_common`=0, transmit timing uses `tx_clk` and `tx_sync`.
- R9: On a transmit bit event in a slot owned by d in 1..5, `tx_data` takes `tx_src[d-1]` and bit d-1 of `tx_stb` pulses in the same clock, with the slot index on `tx_slot`. The transmit table is independent of the receive table (`tbl_dir`=1 selects transmit).
- R10: A slot is 8 bits, and the slot index restarts at 0 on every detected sync.
- R11: While `en`=0, no strobe is issued and `tx_data` is 1. After `en` rises, nothing is routed until the first sync.
- R12: Table writes (`tbl_we`) take effect only while `en`=0, and are ignored while enabled.
- R13: After reset, `rx_stb` and `tx_stb` are 0, `rx_slot` and `tx_slot` are 0, and `tx_data` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; line signals are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; arms both directions to wait for sync |
| cfg_common | input | 1 | Transmit timing taken from receive clock and sync pins |
| cfg_tx_on_fall | input | 1 | Transmit launches on the falling edge, receive samples on the rising edge |
| cfg_sync_rise | input | 1 | Sync sampled on the rising edge |
| cfg_sync_low | input | 1 | Sync active low |
| cfg_dbl | input | 1 | Line clock runs at twice the bit rate |
| cfg_rx_dly | input | 2 | Receive sync-to-first-bit delay in bits |
| cfg_tx_dly | input | 2 | Transmit sync-to-first-bit delay in bits |
| cfg_rx_cnt | input | 7 | Number of valid receive table entries (0..64) |
| cfg_tx_cnt | input | 7 | Number of valid transmit table entries (0..64) |
| tbl_we | input | 1 | Table write strobe |
| tbl_dir | input | 1 | Table select: 0 receive, 1 transmit |
| tbl_addr | input | 6 | Entry address |
| tbl_len | input | 6 | Run length minus one |
| tbl_dst | input | 3 | Destination code |
| rx_clk | input | 1 | Receive line clock |
| rx_sync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Receive serial data |
| tx_clk | input | 1 | Transmit line clock |
| tx_sync | input | 1 | Transmit frame sync |
| tx_src | input | 5 | Current transmit bit from each controller |
| rx_stb | output | 5 | One-hot receive bit strobe per controller |
| rx_bit | output | 1 | Received bit value |
| rx_slot | output | 8 | Slot index of the received bit |
| tx_data | output | 1 | Transmit serial data |
| tx_stb | output | 5 | One-hot transmit bit-taken strobe per controller |
| tx_slot | output | 8 | Slot index of the transmitted bit |

## Verification
The routing function is tried with five input patterns:
- a mixed table in which unrouted runs sit between routed runs, which shows whether run boundaries fall on the right slots;
- a table of single-slot runs that ends before the frame does, which separates slots past the table end from routed slots;
- a table using the unused destination code 7, which exposes any decoding of out-of-range codes;
- a single maximum-length run, which checks that the run-length code covers its full span;
- an empty table.

Each pattern is paired with a different mix of delays, clock edge, sync edge, sync polarity, double speed and shared pins. A wrong choice in any of these moves bits by whole clock periods, so the sampled data or the transmit line no longer match.

Two further stimuli complete the set. Table writes made while enabled show whether the running table is frozen. A disabled run with sync pulses present shows that the block stays quiet.

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
  parameter int N_CTRL    = 5,
  parameter int TBL_DEPTH = 64,
  parameter int MAX_RUN   = 64,
  parameter int SLOT_BITS = 8,
  parameter int SLOT_W    = 8,
  localparam int AW    = $clog2(TBL_DEPTH),
  localparam int CNT_W = $clog2(TBL_DEPTH + 1),
  localparam int LEN_W = $clog2(MAX_RUN),
  localparam int DST_W = $clog2(N_CTRL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_common,
  input  logic              cfg_tx_on_fall,
  input  logic              cfg_sync_rise,
  input  logic              cfg_sync_low,
  input  logic              cfg_dbl,
  input  logic [1:0]        cfg_rx_dly,
  input  logic [1:0]        cfg_tx_dly,
  input  logic [CNT_W-1:0]  cfg_rx_cnt,
  input  logic [CNT_W-1:0]  cfg_tx_cnt,
  input  logic              tbl_we,
  input  logic              tbl_dir,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic [DST_W-1:0]  tbl_dst,
  input  logic              rx_clk,
  input  logic              rx_sync,
  input  logic              rx_data,
  input  logic              tx_clk,
  input  logic              tx_sync,
  input  logic [N_CTRL-1:0] tx_src,
  output logic [N_CTRL-1:0] rx_stb,
  output logic              rx_bit,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              tx_data,
  output logic [N_CTRL-1:0] tx_stb,
  output logic [SLOT_W-1:0] tx_slot
);
  localparam int BIT_W = $clog2(SLOT_BITS);

  logic [LEN_W-1:0] len_m [2][TBL_DEPTH];
  logic [DST_W-1:0] dst_m [2][TBL_DEPTH];

  logic              tick_o [2];
  logic [SLOT_W-1:0] slot_o [2];
  logic [DST_W-1:0]  dst_o  [2];

  function automatic logic [N_CTRL-1:0] dec(input logic [DST_W-1:0] d);
    dec = '0;
    for (int i = 0; i < N_CTRL; i++)
      if (d == DST_W'(i + 1)) dec[i] = 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (tbl_we && !en) begin
      len_m[tbl_dir][tbl_addr] <= tbl_len;
      dst_m[tbl_dir][tbl_addr] <= tbl_dst;
    end

  for (genvar g = 0; g < 2; g++) begin : g_dir
    logic ck, sy, ck_q, rise, fall, dedge, sedge, hit, step, bit_ev, in_tbl, slot_end;
    logic run, div;
    logic [1:0]        dly, dly_cfg;
    logic [BIT_W-1:0]  bcnt;
    logic [SLOT_W-1:0] slot;
    logic [CNT_W-1:0]  ptr, cnt_raw, cnt_eff;
    logic [LEN_W-1:0]  rcnt;

    assign ck       = (g == 0 || cfg_common) ? rx_clk : tx_clk;
    assign sy       = (g == 0 || cfg_common) ? rx_sync : tx_sync;
    assign dly_cfg  = (g == 0) ? cfg_rx_dly : cfg_tx_dly;
    assign cnt_raw  = (g == 0) ? cfg_rx_cnt : cfg_tx_cnt;
    assign cnt_eff  = (cnt_raw > CNT_W'(TBL_DEPTH)) ? CNT_W'(TBL_DEPTH) : cnt_raw;
    assign rise     = ck & ~ck_q;
    assign fall     = ~ck & ck_q;
    assign dedge    = (cfg_tx_on_fall ^ (g == 1)) ? rise : fall;
    assign sedge    = cfg_sync_rise ? rise : fall;
    assign hit      = en & sedge & (sy ^ cfg_sync_low);
    assign step     = en & run & dedge & ~hit;
    assign bit_ev   = step & (~cfg_dbl | div);
    assign tick_o[g] = bit_ev & (dly == 2'd0);
    assign slot_end = tick_o[g] & (bcnt == BIT_W'(SLOT_BITS - 1));
    assign in_tbl   = ptr < cnt_eff;
    assign dst_o[g] = in_tbl ? dst_m[g][ptr[AW-1:0]] : '0;
    assign slot_o[g] = slot;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ck_q <= 1'b0; run <= 1'b0; div <= 1'b0; dly <= '0;
        bcnt <= '0; slot <= '0; ptr <= '0; rcnt <= '0;
      end else begin
        ck_q <= ck;
        if (!en) begin
          run <= 1'b0;
        end else if (hit) begin
          run <= 1'b1; div <= 1'b0; dly <= dly_cfg;
          bcnt <= '0; slot <= '0; ptr <= '0; rcnt <= '0;
        end else begin
          if (step) div <= cfg_dbl & ~div;
          if (bit_ev && dly != 2'd0) dly <= dly - 2'd1;
          if (tick_o[g]) bcnt <= slot_end ? '0 : bcnt + 1'b1;
          if (slot_end) begin
            slot <= slot + 1'b1;
            if (in_tbl) begin
              if (rcnt == len_m[g][ptr[AW-1:0]]) begin
                ptr  <= ptr + 1'b1;
                rcnt <= '0;
              end else begin
                rcnt <= rcnt + 1'b1;
              end
            end
          end
        end
      end
  end

  logic [N_CTRL-1:0] rx_oh, tx_oh;
  assign rx_oh = dec(dst_o[0]);
  assign tx_oh = dec(dst_o[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_stb <= '0; rx_bit <= 1'b0; rx_slot <= '0;
      tx_stb <= '0; tx_data <= 1'b1; tx_slot <= '0;
    end else begin
      rx_stb <= tick_o[0] ? rx_oh : '0;
      if (tick_o[0]) begin
        rx_bit  <= rx_data;
        rx_slot <= slot_o[0];
      end
      tx_stb <= tick_o[1] ? tx_oh : '0;
      if (!en) tx_data <= 1'b1;
      else if (tick_o[1]) begin
        tx_data <= (tx_oh == '0) ? 1'b1 : |(tx_oh & tx_src);
        tx_slot <= slot_o[1];
      end
    end

  a_r2_rx_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rx_stb));
  a_r9_tx_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_stb));
  a_r11_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_stb == '0 && tx_stb == '0 && tx_data));
  a_r9_tx_from_src: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb != '0) |-> (tx_data == |(tx_stb & $past(tx_src))));
  a_r2_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_o[1]) && tx_stb == '0) |-> tx_data);
endmodule

// File: tb/tdm_slot_router_tb.sv
`timescale 1ns/1ps
module tdm_slot_router_tb;
  localparam int P = 2;
  localparam int H = 3;

  logic clk = 0, rst_n = 0, en = 0;
  logic cfg_common = 0, cfg_tx_on_fall = 0, cfg_sync_rise = 0, cfg_sync_low = 0, cfg_dbl = 0;
  logic [1:0] cfg_rx_dly = 0, cfg_tx_dly = 0;
  logic [6:0] cfg_rx_cnt = 0, cfg_tx_cnt = 0;
  logic tbl_we = 0, tbl_dir = 0;
  logic [5:0] tbl_addr = 0, tbl_len = 0;
  logic [2:0] tbl_dst = 0;
  logic rx_clk = 0, rx_sync = 0, rx_data = 0, tx_clk = 0, tx_sync = 0;
  logic [4:0] tx_src = 5'b10110;
  logic [4:0] rx_stb, tx_stb;
  logic rx_bit, tx_data;
  logic [7:0] rx_slot, tx_slot;

  tdm_slot_router u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_common(cfg_common), .cfg_tx_on_fall(cfg_tx_on_fall),
    .cfg_sync_rise(cfg_sync_rise), .cfg_sync_low(cfg_sync_low), .cfg_dbl(cfg_dbl),
    .cfg_rx_dly(cfg_rx_dly), .cfg_tx_dly(cfg_tx_dly), .cfg_rx_cnt(cfg_rx_cnt), .cfg_tx_cnt(cfg_tx_cnt),
    .tbl_we(tbl_we), .tbl_dir(tbl_dir), .tbl_addr(tbl_addr), .tbl_len(tbl_len), .tbl_dst(tbl_dst),
    .rx_clk(rx_clk), .rx_sync(rx_sync), .rx_data(rx_data), .tx_clk(tx_clk), .tx_sync(tx_sync),
    .tx_src(tx_src), .rx_stb(rx_stb), .rx_bit(rx_bit), .rx_slot(rx_slot),
    .tx_data(tx_data), .tx_stb(tx_stb), .tx_slot(tx_slot));

  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0] tbl; logic [3:0] nsl; logic [1:0] dr; logic [1:0] dt;
    logic dbl; logic slow; logic com; logic tof; logic e2;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{tbl:2'd0, nsl:4'd8, dr:2'd0, dt:2'd0, dbl:1'b0, slow:1'b0, com:1'b1, tof:1'b1, e2:1'b0},
    '{tbl:2'd0, nsl:4'd8, dr:2'd3, dt:2'd1, dbl:1'b0, slow:1'b1, com:1'b0, tof:1'b0, e2:1'b0},
    '{tbl:2'd1, nsl:4'd7, dr:2'd1, dt:2'd2, dbl:1'b1, slow:1'b0, com:1'b0, tof:1'b1, e2:1'b1},
    '{tbl:2'd2, nsl:4'd4, dr:2'd2, dt:2'd3, dbl:1'b0, slow:1'b0, com:1'b1, tof:1'b0, e2:1'b1},
    '{tbl:2'd3, nsl:4'd4, dr:2'd0, dt:2'd0, dbl:1'b1, slow:1'b1, com:1'b1, tof:1'b1, e2:1'b0},
    '{tbl:2'd1, nsl:4'd7, dr:2'd0, dt:2'd0, dbl:1'b0, slow:1'b0, com:1'b0, tof:1'b0, e2:1'b0}
  };

  int nchk = 0, nbad = 0;
  int tlen [4][8], tdst [4][8], tcnt [4];
  int rx_n, tx_n;
  int rx_c [1024], rx_b [1024], rx_s [1024], tx_c [1024], tx_s [1024];
  int txline [512];
  int es [5];
  int cur_dbl, cur_dr, cur_dt, cur_ts, cur_v;
  logic inv, slow_q, com_q;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rx_stb != 0) begin
      for (int i = 0; i < 5; i++) if (rx_stb[i]) rx_c[rx_n] = i;
      rx_b[rx_n] = rx_bit; rx_s[rx_n] = rx_slot; rx_n++;
    end
    if (tx_stb != 0) begin
      for (int i = 0; i < 5; i++) if (tx_stb[i]) begin tx_c[tx_n] = i; tx_src[i] = ~tx_src[i]; end
      tx_s[tx_n] = tx_slot; tx_n++;
    end
  end

  function automatic int txmap(input int d);
    return (d >= 1 && d <= 5) ? (d % 5) + 1 : d;
  endfunction

  function automatic int mdest(input int t, input int s, input bit tx, input bit empty);
    int acc = 0;
    if (empty) return 0;
    for (int e = 0; e < tcnt[t]; e++) begin
      if (s < acc + tlen[t][e]) begin
        int d = tx ? txmap(tdst[t][e]) : tdst[t][e];
        return (d >= 1 && d <= 5) ? d : 0;
      end
      acc += tlen[t][e];
    end
    return 0;
  endfunction

  function automatic int rxpat(input int k);
    return ((k ^ (k >> 2)) + cur_v) & 1;
  endfunction
  function automatic int rxcyc(input int j);
    return P + (cur_dbl != 0 ? 2 * (cur_dr + 1 + j) : cur_dr + 1 + j);
  endfunction
  function automatic int txc(input int j);
    return P + cur_ts + (cur_dbl != 0 ? 2 * (cur_dt + j) + 1 : cur_dt + j);
  endfunction

  task automatic wr(input bit dir, input int a, input int len, input int d);
    tbl_dir = dir; tbl_addr = 6'(a); tbl_len = 6'(len - 1); tbl_dst = 3'(d); tbl_we = 1;
    wait_n(1);
    tbl_we = 0;
  endtask

  task automatic tdm_cycle(input int k);
    txline[k] = tx_data;
    rx_data = 1'(rxpat(k));
    rx_sync = (k == P) ^ slow_q;
    tx_sync = com_q ? 1'b0 : ((k == P + 1) ^ slow_q);
    wait_n(H);
    rx_clk = ~inv; tx_clk = com_q ? 1'b0 : ~inv;
    wait_n(H);
    rx_clk = inv;  tx_clk = com_q ? 1'b0 : inv;
    wait_n(H);
  endtask

  task automatic run_vec(input int vi, input bit load, input bit poke, input bit empty, input bit off, input string tag);
    vec_t v = VEC[vi];
    int t = v.tbl, nb, n, er = 0, et = 0, rgood = 0, tgood = 0;
    en = 0;
    wait_n(2);
    cfg_common = v.com; cfg_tx_on_fall = v.tof; cfg_sync_rise = v.tof ^ v.e2;
    cfg_sync_low = v.slow; cfg_dbl = v.dbl; cfg_rx_dly = v.dr; cfg_tx_dly = v.dt;
    inv = ~v.tof; slow_q = v.slow; com_q = v.com;
    rx_clk = inv; tx_clk = v.com ? 1'b0 : inv;
    rx_sync = v.slow; tx_sync = v.com ? 1'b0 : v.slow;
    cfg_rx_cnt = empty ? 7'd0 : 7'(tcnt[t]);
    cfg_tx_cnt = cfg_rx_cnt;
    if (load)
      for (int e = 0; e < tcnt[t]; e++) begin
        wr(0, e, tlen[t][e], tdst[t][e]);
        wr(1, e, tlen[t][e], txmap(tdst[t][e]));
      end
    wait_n(3);
    en = ~off;
    wait_n(2);
    if (poke)
      for (int e = 0; e < 4; e++) begin wr(0, e, 8, 1); wr(1, e, 8, 1); end
    cur_v = vi; cur_dbl = v.dbl; cur_dr = v.dr; cur_dt = v.dt;
    cur_ts = (v.com ? 0 : 1) + v.e2;
    for (int i = 0; i < 5; i++) es[i] = tx_src[i];
    rx_n = 0; tx_n = 0;
    nb = 8 * v.nsl;
    n = ((rxcyc(nb - 1) > txc(nb - 1) + 1) ? rxcyc(nb - 1) : txc(nb - 1) + 1) + 2;
    for (int k = 0; k < n; k++) tdm_cycle(k);
    for (int k = 0; k < P; k++) chk(txline[k] == 1, "R11", "tx idle before sync", txline[k], 1);
    for (int j = 0; j < nb; j++) begin
      int s = j / 8;
      int dr_ = off ? 0 : mdest(t, s, 0, empty);
      int dt_ = off ? 0 : mdest(t, s, 1, empty);
      int eb  = (dt_ != 0) ? es[dt_ - 1] : 1;
      if (dr_ != 0) begin
        if (er < rx_n) begin
          chk(rx_c[er] == dr_ - 1, "R1", "rx controller", rx_c[er], dr_ - 1);
          chk(rx_b[er] == rxpat(rxcyc(j)), tag, "rx bit", rx_b[er], rxpat(rxcyc(j)));
          chk(rx_s[er] == s, "R10", "rx slot", rx_s[er], s);
        end
        er++;
      end
      chk(txline[txc(j) + 1] == eb, tag, "tx line bit", txline[txc(j) + 1], eb);
      if (dt_ != 0) begin
        if (et < tx_n) begin
          chk(tx_c[et] == dt_ - 1, "R9", "tx controller", tx_c[et], dt_ - 1);
          chk(tx_s[et] == s, "R10", "tx slot", tx_s[et], s);
        end
        es[dt_ - 1] = ~es[dt_ - 1] & 1;
        et++;
      end
    end
    for (int i = 0; i < rx_n; i++) if (rx_s[i] < v.nsl) rgood++;
    for (int i = 0; i < tx_n; i++) if (tx_s[i] < v.nsl) tgood++;
    chk(rgood == er, "R2", "rx strobe count", rgood, er);
    chk(tgood == et, "R9", "tx strobe count", tgood, et);
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    #(8ns * 150000);
    chk(0, "R11", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    tcnt[0] = 4; tlen[0][0] = 2; tdst[0][0] = 0; tlen[0][1] = 3; tdst[0][1] = 4;
    tlen[0][2] = 1; tdst[0][2] = 0; tlen[0][3] = 2; tdst[0][3] = 3;
    tcnt[1] = 5;
    for (int e = 0; e < 5; e++) begin tlen[1][e] = 1; tdst[1][e] = e + 1; end
    tcnt[2] = 2; tlen[2][0] = 2; tdst[2][0] = 7; tlen[2][1] = 1; tdst[2][1] = 5;
    tcnt[3] = 1; tlen[3][0] = 64; tdst[3][0] = 2;

    wait_n(3);
    rst_n = 1;
    wait_n(2);
    chk(rx_stb == 0, "R13", "rx_stb after reset", rx_stb, 0);
    chk(tx_stb == 0, "R13", "tx_stb after reset", tx_stb, 0);
    chk(tx_data == 1, "R13", "tx_data after reset", tx_data, 1);
    chk(rx_slot == 0 && tx_slot == 0, "R13", "slot after reset", rx_slot, 0);

    run_vec(0, 1, 0, 0, 0, "R8");
    run_vec(1, 1, 0, 0, 0, "R6");
    run_vec(2, 1, 0, 0, 0, "R7");
    run_vec(3, 1, 0, 0, 0, "R4");
    run_vec(4, 1, 0, 0, 0, "R1");
    run_vec(5, 1, 0, 0, 0, "R5");

    run_vec(0, 1, 1, 0, 0, "R12");
    run_vec(0, 0, 0, 0, 0, "R12");
    run_vec(2, 1, 0, 1, 0, "R3");
    run_vec(1, 1, 0, 0, 1, "R11");
    finish_up();
  end
endmodule